// File: doc/BRIEF.md
# Self-Routing Omega Network

This block is a multistage interconnect between P = 2^N source ports and P destination ports. It is built from N columns of 2x2 switches. Before each column, the lines are rewired by a perfect shuffle. Each source port presents a valid bit, a payload word and the number of the destination port it wants. Nothing programs the switches from outside. Every switch sets itself from the address bits of the packets that reach it.

The network does not buffer anything. When two packets meet at one switch and both need the same switch output, the packet on the upper input goes through. The other packet is discarded, and the source that sent it is flagged as blocked in that cycle. Each destination port reports whether a packet arrived, the payload, and the number of the source port that sent it.

An optional register stage sits on the outputs. It is on by default, which gives a latency of one clock. The network accepts a new set of packets on every cycle.

Top module: `omega_network`

## Requirements
- R1: A single valid packet entering at source port i with destination d appears on output port d one clock later (REG_OUT=1), carrying its payload unchanged.
- R2: Before stage s (s = 0 first), the lines are reordered so that the packet on line k moves to the line whose N-bit index is k rotated left by one bit. Switch m of a stage joins line 2m (upper) and line 2m+1 (lower). The switch passes straight when bit N-1-s of the packet's source index equals bit N-1-s of its destination, and crosses otherwise. A packet from 010 to 111 therefore leaves on port 7, and a packet from 110 to 101 leaves on port 5.
- R3: When the two valid packets at a switch need different switch modes, the upper one is routed and the lower one is discarded. The discarded packet's source sets blocked[src] = 1 and appears on no output. For example, sending 0 to port 0 and 4 to port 1 in the same cycle delivers source 0 on port 0 and raises blocked bit 4.
- R4: The identity permutation and every cyclic shift (source i to port (i+k) mod P) reach all P ports with no blocked flag.
- R5: A source with valid low produces no output packet and never raises its blocked bit. An invalid packet on a switch's upper input never causes the lower packet to be discarded.
- R6: While the synchronous active-high reset is asserted, out_valid and blocked are all zero at the next clock.
- R7: A new input set is accepted every cycle. The outputs sampled after a clock edge depend only on the inputs present at that edge.
- R8: Every valid source is either delivered on exactly one output port or flagged blocked, never both. The number of valid outputs plus the number of blocked flags equals the number of valid inputs.
- R9: out_src of a valid output port equals the index of the source port whose packet it carries.
- R10: P is a power of two from 4 to 32, and the payload width is an independent parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | P | Per-source packet valid |
| in_dst | input | P*N | Per-source destination index, N bits per source |
| in_payload | input | P*PW | Per-source payload, PW bits per source |
| out_valid | output | P | Per-destination arrival flag |
| out_src | output | P*N | Source index of the packet on each destination port |
| out_payload | output | P*PW | Payload on each destination port |
| blocked | output | P | Per-source flag: that source's packet was discarded in a conflict |

## Verification
The switch checks rely on an invariant: when a packet reaches stage s, bit N-1-s of its source index equals the low bit of the line it sits on. That invariant holds only if the top level fills each lane's source field with the port number. The output checks compare each delivered packet with a copy of the valid and destination inputs from the previous clock, so they depend on REG_OUT=1. All stimulus is applied exactly one half-period before the capturing edge: single packets over every source and destination pair, the two worked routes, permutations, forced conflicts, and random partly valid sets. Conflict outcomes are predicted by stepping each packet through the line rotation and the upper-wins rule.

// File: rtl/omega_pkg.sv
package omega_pkg;

    typedef enum logic {
        SW_PASS  = 1'b0,
        SW_CROSS = 1'b1
    } sw_mode_e;

    // Perfect-shuffle line map: rotate an n-bit index left by one.
    function automatic int unsigned shuffle_idx(input int unsigned idx, input int unsigned n);
        int unsigned mask;
        mask = (32'd1 << n) - 32'd1;
        return ((idx << 1) | (idx >> (n - 1))) & mask;
    endfunction

    // Straight when the examined address bits agree, crossed otherwise.
    function automatic sw_mode_e pick_mode(input logic s_bit, input logic d_bit);
        return (s_bit == d_bit) ? SW_PASS : SW_CROSS;
    endfunction

    function automatic bit ports_legal(input int unsigned p);
        return (p >= 4) && (p <= 32) && ((p & (p - 1)) == 0);
    endfunction

endpackage

// File: rtl/omega_switch2.sv
module omega_switch2 #(
    parameter int N   = 3,
    parameter int PW  = 8,
    parameter int BIT = 2,
    localparam int LW = 1 + 2 * N + PW
) (
    input  logic [LW-1:0] in_u,
    input  logic [LW-1:0] in_l,
    output logic [LW-1:0] out_u,
    output logic [LW-1:0] out_l,
    output logic          lose_l
);
    import omega_pkg::*;

    typedef struct packed {
        logic          vld;
        logic [N-1:0]  dst;
        logic [N-1:0]  src;
        logic [PW-1:0] pay;
    } lane_t;

    lane_t    up, lo, lo_eff, o_up, o_lo;
    sw_mode_e mode_up, mode_lo, mode;
    logic     clash;

    always_comb begin
        up      = lane_t'(in_u);
        lo      = lane_t'(in_l);
        mode_up = pick_mode(up.src[BIT], up.dst[BIT]);
        mode_lo = pick_mode(lo.src[BIT], lo.dst[BIT]);
        clash   = up.vld && lo.vld && (mode_up != mode_lo);
        lo_eff  = lo;
        if (clash) lo_eff.vld = 1'b0;
        if (up.vld)      mode = mode_up;
        else if (lo.vld) mode = mode_lo;
        else             mode = SW_PASS;
        if (mode == SW_PASS) begin
            o_up = up;
            o_lo = lo_eff;
        end else begin
            o_up = lo_eff;
            o_lo = up;
        end
    end

    assign out_u  = LW'(o_up);
    assign out_l  = LW'(o_lo);
    assign lose_l = clash;

    // R2
    always_comb begin
        if (o_up.vld === 1'b1) upper_exit_bit_chk: assert (o_up.dst[BIT] == 1'b0);
        if (o_lo.vld === 1'b1) lower_exit_bit_chk: assert (o_lo.dst[BIT] == 1'b1);
    end

    // R5
    always_comb begin
        if (lose_l === 1'b1) drop_needs_upper_chk: assert (up.vld && (o_up.vld || o_lo.vld));
    end

endmodule

// File: rtl/omega_stage.sv
module omega_stage #(
    parameter int N     = 3,
    parameter int PW    = 8,
    parameter int STAGE = 0,
    localparam int P    = 1 << N,
    localparam int LW   = 1 + 2 * N + PW,
    localparam int BIT  = N - 1 - STAGE
) (
    input  logic [LW-1:0] lanes_i [P],
    output logic [LW-1:0] lanes_o [P],
    output logic [P-1:0]  drop_o
);
    import omega_pkg::*;

    typedef struct packed {
        logic          vld;
        logic [N-1:0]  dst;
        logic [N-1:0]  src;
        logic [PW-1:0] pay;
    } lane_t;

    logic [LW-1:0] shuf [P];
    logic [P/2-1:0] lose;
    logic [N-1:0]  lo_src [P/2];

    for (genvar k = 0; k < P; k++) begin : g_shuffle
        localparam int DST_LINE = int'(shuffle_idx(k, N));
        assign shuf[DST_LINE] = lanes_i[k];
    end

    for (genvar m = 0; m < P / 2; m++) begin : g_sw
        lane_t lo_view;
        assign lo_view   = lane_t'(shuf[2*m+1]);
        assign lo_src[m] = lo_view.src;

        omega_switch2 #(.N(N), .PW(PW), .BIT(BIT)) sw_i (
            .in_u   (shuf[2*m]),
            .in_l   (shuf[2*m+1]),
            .out_u  (lanes_o[2*m]),
            .out_l  (lanes_o[2*m+1]),
            .lose_l (lose[m])
        );
    end

    always_comb begin
        drop_o = '0;
        for (int m = 0; m < P / 2; m++) begin
            if (lose[m]) drop_o[lo_src[m]] = 1'b1;
        end
    end

endmodule

// File: rtl/omega_network.sv
module omega_network #(
    parameter int P       = 8,
    parameter int PW      = 8,
    parameter bit REG_OUT = 1'b1,
    localparam int N      = $clog2(P),
    localparam int LW     = 1 + 2 * N + PW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [P-1:0]    in_valid,
    input  logic [P*N-1:0]  in_dst,
    input  logic [P*PW-1:0] in_payload,
    output logic [P-1:0]    out_valid,
    output logic [P*N-1:0]  out_src,
    output logic [P*PW-1:0] out_payload,
    output logic [P-1:0]    blocked
);
    import omega_pkg::*;

    typedef struct packed {
        logic          vld;
        logic [N-1:0]  dst;
        logic [N-1:0]  src;
        logic [PW-1:0] pay;
    } lane_t;

    // R10
    initial begin
        port_count_legal_chk: assert (ports_legal(P));
    end

    logic [LW-1:0] chain [N+1][P];
    logic [P-1:0]  drops [N];
    logic [P-1:0]  nxt_valid, nxt_blocked;
    logic [P*N-1:0]  nxt_src;
    logic [P*PW-1:0] nxt_pay;
    lane_t         fin [P];

    for (genvar i = 0; i < P; i++) begin : g_entry
        lane_t ent;
        always_comb begin
            ent.vld = in_valid[i];
            ent.dst = in_dst[i*N +: N];
            ent.src = N'(i);
            ent.pay = in_payload[i*PW +: PW];
        end
        assign chain[0][i] = LW'(ent);
    end

    for (genvar s = 0; s < N; s++) begin : g_stage
        omega_stage #(.N(N), .PW(PW), .STAGE(s)) stage_i (
            .lanes_i (chain[s]),
            .lanes_o (chain[s+1]),
            .drop_o  (drops[s])
        );
    end

    for (genvar j = 0; j < P; j++) begin : g_exit
        assign fin[j]               = lane_t'(chain[N][j]);
        assign nxt_valid[j]         = fin[j].vld;
        assign nxt_src[j*N +: N]    = fin[j].src;
        assign nxt_pay[j*PW +: PW]  = fin[j].pay;

        // R1
        always_comb begin
            if (fin[j].vld === 1'b1) final_line_dst_chk: assert (fin[j].dst == N'(j));
        end
    end

    always_comb begin
        nxt_blocked = '0;
        for (int s = 0; s < N; s++) nxt_blocked |= drops[s];
    end

    if (REG_OUT) begin : g_reg
        logic [P-1:0] vld_prev;
        logic [N-1:0] dst_prev [P];

        always_ff @(posedge clk) begin
            if (rst) begin
                out_valid   <= '0;
                blocked     <= '0;
                out_src     <= '0;
                out_payload <= '0;
            end else begin
                out_valid   <= nxt_valid;
                blocked     <= nxt_blocked;
                out_src     <= nxt_src;
                out_payload <= nxt_pay;
            end
        end

        // Input copies used only by the output checks below.
        always_ff @(posedge clk) begin
            vld_prev <= in_valid;
            for (int i = 0; i < P; i++) dst_prev[i] <= in_dst[i*N +: N];
        end

        // R6
        reset_clears_chk: assert property (@(posedge clk)
            rst |=> (out_valid == '0) && (blocked == '0));

        // R8
        conservation_chk: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> ($countones(out_valid) + $countones(blocked)
                             == $countones(vld_prev)));

        // R5
        blocked_only_valid_chk: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> ((blocked & ~vld_prev) == '0));

        for (genvar j = 0; j < P; j++) begin : g_dst_chk
            // R9
            delivered_match_chk: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && out_valid[j]) |->
                    (vld_prev[out_src[j*N +: N]] &&
                     dst_prev[out_src[j*N +: N]] == N'(j) &&
                     !blocked[out_src[j*N +: N]]));
        end
    end else begin : g_comb
        assign out_valid   = nxt_valid;
        assign blocked     = nxt_blocked;
        assign out_src     = nxt_src;
        assign out_payload = nxt_pay;
    end

endmodule

// File: tb/omega_network_tb.sv
module omega_network_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int P  = 8;
    localparam int PW = 8;
    localparam int N  = $clog2(P);

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [P-1:0]    in_valid = '0;
    logic [P*N-1:0]  in_dst = '0;
    logic [P*PW-1:0] in_payload = '0;
    logic [P-1:0]    out_valid;
    logic [P*N-1:0]  out_src;
    logic [P*PW-1:0] out_payload;
    logic [P-1:0]    blocked;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic [P-1:0]    vld;
        logic [P-1:0]    blk;
        logic [P*N-1:0]  src;
        logic [P*PW-1:0] pay;
        string           tag;
    } exp_t;

    exp_t sb_q [$];

    omega_network #(.P(P), .PW(PW), .REG_OUT(1'b1)) dut_i (
        .clk (clk), .rst (rst),
        .in_valid (in_valid), .in_dst (in_dst), .in_payload (in_payload),
        .out_valid (out_valid), .out_src (out_src),
        .out_payload (out_payload), .blocked (blocked)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    // Reference from the requirements: rotate-left line map, upper wins on clash.
    function automatic exp_t model(input logic [P-1:0] v, input logic [P*N-1:0] d,
                                   input logic [P*PW-1:0] pl, input string tag);
        exp_t e;
        int pos [P];
        int pre [P];
        bit alive [P];
        bit lose [P];
        e.vld = '0; e.blk = '0; e.src = '0; e.pay = '0; e.tag = tag;
        for (int i = 0; i < P; i++) begin
            pos[i] = i;
            alive[i] = v[i];
        end
        for (int s = 0; s < N; s++) begin
            int b = N - 1 - s;
            for (int i = 0; i < P; i++)
                pre[i] = ((pos[i] << 1) | (pos[i] >> (N - 1))) & (P - 1);
            for (int i = 0; i < P; i++) begin
                lose[i] = 1'b0;
                if (alive[i] && pre[i][0]) begin
                    for (int j = 0; j < P; j++) begin
                        if (alive[j] && j != i && pre[j] == pre[i] - 1 &&
                            d[i*N + b] == d[j*N + b])
                            lose[i] = 1'b1;
                    end
                end
            end
            for (int i = 0; i < P; i++) begin
                if (alive[i]) begin
                    if (lose[i]) begin
                        alive[i] = 1'b0;
                        e.blk[i] = 1'b1;
                    end else begin
                        pos[i] = (pre[i] & ~1) | int'(d[i*N + b]);
                    end
                end
            end
        end
        for (int i = 0; i < P; i++) begin
            if (alive[i]) begin
                e.vld[pos[i]] = 1'b1;
                e.src[pos[i]*N +: N] = N'(i);
                e.pay[pos[i]*PW +: PW] = pl[i*PW +: PW];
            end
        end
        return e;
    endfunction

    // Driver: apply one input set half a period before the capturing edge.
    task automatic send_exp(input logic [P-1:0] v, input logic [P*N-1:0] d,
                            input logic [P*PW-1:0] pl, input exp_t e);
        @(negedge clk);
        in_valid = v; in_dst = d; in_payload = pl;
        sb_q.push_back(e);
    endtask

    task automatic send(input logic [P-1:0] v, input logic [P*N-1:0] d,
                        input logic [P*PW-1:0] pl, input string tag);
        send_exp(v, d, pl, model(v, d, pl, tag));
    endtask

    // Monitor: one scoreboard entry per edge, checked just after the edge.
    always @(posedge clk) begin
        #1;
        if (!rst && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            for (int j = 0; j < P; j++) begin
                chk(out_valid[j] == e.vld[j], e.tag, $sformatf("out_valid[%0d]", j),
                    int'(out_valid[j]), int'(e.vld[j]));
                chk(blocked[j] == e.blk[j], e.tag, $sformatf("blocked[%0d]", j),
                    int'(blocked[j]), int'(e.blk[j]));
                if (e.vld[j]) begin
                    chk(out_src[j*N +: N] == e.src[j*N +: N], e.tag,
                        $sformatf("out_src[%0d]", j),
                        int'(out_src[j*N +: N]), int'(e.src[j*N +: N]));
                    chk(out_payload[j*PW +: PW] == e.pay[j*PW +: PW], e.tag,
                        $sformatf("out_payload[%0d]", j),
                        int'(out_payload[j*PW +: PW]), int'(e.pay[j*PW +: PW]));
                end
            end
        end
    end

    function automatic logic [P*N-1:0] perm_dst(input int shift);
        logic [P*N-1:0] d;
        for (int i = 0; i < P; i++) d[i*N +: N] = N'((i + shift) % P);
        return d;
    endfunction

    function automatic logic [P*PW-1:0] rand_pay();
        logic [P*PW-1:0] pl;
        for (int i = 0; i < P; i++) pl[i*PW +: PW] = PW'($urandom);
        return pl;
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog run did not finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        exp_t e;
        logic [P*N-1:0]  d;
        logic [P*PW-1:0] pl;

        // R6: hold reset with every input valid
        in_valid = '1;
        in_dst = perm_dst(0);
        in_payload = rand_pay();
        repeat (3) @(posedge clk);
        #1;
        chk(out_valid == '0, "R6", "out_valid in reset", int'(out_valid), 0);
        chk(blocked == '0, "R6", "blocked in reset", int'(blocked), 0);
        @(negedge clk);
        rst = 1'b0;
        in_valid = '0;
        @(negedge clk);

        // R1 R9: every source to every destination, one at a time, back to back (R7)
        for (int s = 0; s < P; s++) begin
            for (int t = 0; t < P; t++) begin
                d = '0;
                d[s*N +: N] = N'(t);
                pl = rand_pay();
                e.vld = '0; e.blk = '0; e.src = '0; e.pay = '0; e.tag = "R1";
                e.vld[t] = 1'b1;
                e.src[t*N +: N] = N'(s);
                e.pay[t*PW +: PW] = pl[s*PW +: PW];
                send_exp(P'(1) << s, d, pl, e);
            end
        end

        // R2: worked routes 010->111 and 110->101, in separate cycles
        d = '0; d[2*N +: N] = 3'b111; pl = rand_pay();
        e.vld = '0; e.blk = '0; e.src = '0; e.pay = '0; e.tag = "R2";
        e.vld[7] = 1'b1; e.src[7*N +: N] = 3'b010; e.pay[7*PW +: PW] = pl[2*PW +: PW];
        send_exp(P'(1) << 2, d, pl, e);
        d = '0; d[6*N +: N] = 3'b101; pl = rand_pay();
        e.vld = '0; e.blk = '0; e.src = '0; e.pay = '0; e.tag = "R2";
        e.vld[5] = 1'b1; e.src[5*N +: N] = 3'b110; e.pay[5*PW +: PW] = pl[6*PW +: PW];
        send_exp(P'(1) << 6, d, pl, e);

        // R3: 0->0 and 4->1 meet at the first switch; source 4 is lower and loses
        d = '0; d[0 +: N] = 3'd0; d[4*N +: N] = 3'd1; pl = rand_pay();
        e.vld = '0; e.blk = '0; e.src = '0; e.pay = '0; e.tag = "R3";
        e.vld[0] = 1'b1; e.src[0 +: N] = 3'd0; e.pay[0 +: PW] = pl[0 +: PW];
        e.blk[4] = 1'b1;
        send_exp(8'b0001_0001, d, pl, e);

        // R5: same lower packet alone, upper source invalid, must pass
        e.vld = '0; e.blk = '0; e.src = '0; e.pay = '0; e.tag = "R5";
        e.vld[1] = 1'b1; e.src[1*N +: N] = 3'd4; e.pay[1*PW +: PW] = pl[4*PW +: PW];
        send_exp(8'b0001_0000, d, pl, e);

        // R4: identity and every cyclic shift, all delivered, none blocked
        for (int k = 0; k < P; k++) begin
            pl = rand_pay();
            e.vld = '1; e.blk = '0; e.tag = "R4";
            for (int i = 0; i < P; i++) begin
                e.src[((i + k) % P)*N +: N] = N'(i);
                e.pay[((i + k) % P)*PW +: PW] = pl[i*PW +: PW];
            end
            send_exp('1, perm_dst(k), pl, e);
        end

        // R3 R8: all sources aimed at one port
        for (int t = 0; t < P; t++) begin
            d = '0;
            for (int i = 0; i < P; i++) d[i*N +: N] = N'(t);
            send('1, d, rand_pay(), "R3");
        end

        // R5 R7 R8: random partly valid sets, back to back
        for (int r = 0; r < 400; r++) begin
            for (int i = 0; i < P; i++) d[i*N +: N] = N'($urandom);
            send(P'($urandom), d, rand_pay(), "R8");
        end

        @(negedge clk);
        in_valid = '0;
        send('0, '0, '0, "R5");
        while (sb_q.size() > 0) @(negedge clk);
        @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule